// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Controller

This block is the digital front end of a two-channel, 8-bit voltage DAC. A host writes 16-bit command frames over a three-wire serial port: active-low chip select, serial clock and serial data. The block keeps two double-buffered channels. Each channel has a staging (input) register and an output register that drives the converter. Each channel also has a power-down flag.

The first byte of a frame is a control byte. Each of its bits acts on its own; the byte is not decoded as one code. The bits select which channels take the data byte, whether the channels power down, and whether the output registers copy their staging registers. That copy can happen when the frame ends, or it can wait for a falling edge on an external active-low load strobe.

The serial pins and the load strobe are asynchronous to the system clock. Each one passes through a two-flop synchronizer before any edge detection. The analog ladder and the reference are outside this block.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: While chip select is low, one bit is captured from the data pin on each rising edge of the serial clock, most significant bit first. A frame is 16 bits. Frame bits 15..8 form the control byte, sent in this order: three unused bits, then PWR (bit 12), UPD (bit 11), DEFER (bit 10), SELB (bit 9) and SELA (bit 8). Frame bits 7..0 are the data byte, sent MSB first.
- R2: A frame sent as two 8-bit bursts with an idle pause between them has the same effect as a continuous frame, provided chip select stays low for the whole frame.
- R3: A command takes effect only on the rising edge of chip select. If fewer or more than 16 clock edges were seen while chip select was low, the frame is dropped and no register or flag changes.
- R4: SELA=1 writes the data byte into channel A's staging register. SELB=1 writes it into channel B's staging register. Both bits may be set in one frame, and with both clear no staging register changes. The three unused control bits have no effect.
- R5: With UPD=1 and DEFER=0, both output registers copy their staging registers when chip select rises. With UPD=0, both output registers keep their values.
- R6: When one frame both writes a staging register and requests an update, the output register receives the newly written byte.
- R7: With UPD=1 and DEFER=1, the output registers do not change when the frame ends. Both of them copy their staging registers on the next falling edge of the load strobe.
- R8: A pending deferred update is cancelled when chip select next falls, even if that frame is later dropped. A falling edge of the load strobe with no update pending changes nothing.
- R9: Each selected channel takes PWR as its power-down flag: PWR=1 powers the channel down and PWR=0 powers it up. A channel that is not selected keeps its flag.
- R10: Reset clears every staging register, every output register and both power-down flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; data is captured on its rising edge |
| din_i | input | 1 | Serial data, MSB first |
| load_ni | input | 1 | Load strobe, active low; its falling edge fires a deferred update |
| dac_a_o | output | 8 | Channel A output register |
| dac_b_o | output | 8 | Channel B output register |
| pd_a_o | output | 1 | Channel A power-down flag |
| pd_b_o | output | 1 | Channel B power-down flag |

## Verification
All 32 combinations of the five functional control bits are swept twice, once with continuous frames and once with frames split into two bursts. In each sweep the data bytes and the unused bits vary, and a load-strobe pulse follows every frame. This separates per-channel selection from joint selection, immediate updates from deferred ones, and the cases where power flags are kept from those where they are written. It also shows whether the unused bits leak into the result.

Frames of 0, 8, 15 and 17 bits check that only a frame of exactly 16 bits takes effect. A deferred update followed by a dropped frame shows that the pending update is cancelled. A load pulse with no update pending shows that the strobe alone changes nothing. A staging write followed by an update-only frame exposes the staging register at the outputs.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CTRL_W = 8;
  localparam int NUM_CH = 2;

  // first field is the first bit shifted in (frame bit 15)
  typedef struct packed {
    logic ub1;
    logic ub2;
    logic ub3;
    logic pwr_dn;
    logic upd_en;
    logic upd_defer;
    logic sel_b;
    logic sel_a;
  } ctrl_t;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               din_i,
  output logic               frm_start_o,
  output logic               frm_vld_o,
  output logic [FRAME_W-1:0] frm_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [2:0] pins_s;
  logic cs_s, sclk_s, din_s;
  logic cs_q, sclk_q;
  logic cs_fall, cs_rise, sclk_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shift_q;

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  assign {cs_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_rise = sclk_s & ~sclk_q;

  // count saturates one past full so an overlong frame stays invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_OVER;
      shift_q <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
    end else if (!cs_s && sclk_rise) begin
      shift_q <= {shift_q[FRAME_W-2:0], din_s};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frm_start_o = cs_fall;
  assign frm_vld_o   = cs_rise && (cnt_q == CNT_FULL);
  assign frm_o       = shift_q;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           frm_start_i,
  input  logic                           frm_vld_i,
  input  ctrl_t                          ctrl_i,
  input  logic [DATA_W-1:0]              data_i,
  input  logic                           load_ni,
  output logic [NUM_CH-1:0][DATA_W-1:0]  in_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  dac_o,
  output logic [NUM_CH-1:0]              pd_o,
  output logic                           pend_o,
  output logic                           ld_fall_o
);
  logic load_s, load_q, ld_fall;
  logic pend_q;
  logic upd_now;
  logic [NUM_CH-1:0] sel_vec;
  logic unused_ub;

  assign unused_ub = ^{ctrl_i.ub1, ctrl_i.ub2, ctrl_i.ub3};
  assign sel_vec   = {ctrl_i.sel_b, ctrl_i.sel_a};

  dac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_load_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (load_ni),
    .q_o   (load_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= load_s;
  end

  assign ld_fall = load_q & ~load_s;

  // a frame ending wins over a strobe edge in the same cycle
  assign upd_now = frm_vld_i ? (ctrl_i.upd_en & ~ctrl_i.upd_defer)
                             : (ld_fall & pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (frm_start_i) pend_q <= 1'b0;
    else if (frm_vld_i)   pend_q <= ctrl_i.upd_en & ctrl_i.upd_defer;
    else if (ld_fall)     pend_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DATA_W-1:0] in_q, out_q, in_nxt;
    logic              pd_q;
    logic              wr;

    assign wr     = frm_vld_i & sel_vec[i];
    assign in_nxt = wr ? data_i : in_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q  <= '0;
        out_q <= '0;
        pd_q  <= 1'b0;
      end else begin
        if (wr) begin
          in_q <= data_i;
          pd_q <= ctrl_i.pwr_dn;
        end
        if (upd_now) out_q <= in_nxt;
      end
    end

    assign in_o[i]  = in_q;
    assign dac_o[i] = out_q;
    assign pd_o[i]  = pd_q;
  end

  assign pend_o    = pend_q;
  assign ld_fall_o = ld_fall;
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              load_ni,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic              pd_a_o,
  output logic              pd_b_o
);
  localparam int FRAME_W = CTRL_W + DATA_W;

  logic                          frm_start, frm_vld;
  logic [FRAME_W-1:0]            frm;
  ctrl_t                         ctrl;
  logic [DATA_W-1:0]             data;
  logic [NUM_CH-1:0][DATA_W-1:0] in_regs, dac_regs;
  logic [NUM_CH-1:0]             pd_flags;
  logic                          pend, ld_fall;

  dac_serial_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .din_i      (din_i),
    .frm_start_o(frm_start),
    .frm_vld_o  (frm_vld),
    .frm_o      (frm)
  );

  assign ctrl = ctrl_t'(frm[FRAME_W-1:DATA_W]);
  assign data = frm[DATA_W-1:0];

  dac_reg_bank #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frm_start_i(frm_start),
    .frm_vld_i  (frm_vld),
    .ctrl_i     (ctrl),
    .data_i     (data),
    .load_ni    (load_ni),
    .in_o       (in_regs),
    .dac_o      (dac_regs),
    .pd_o       (pd_flags),
    .pend_o     (pend),
    .ld_fall_o  (ld_fall)
  );

  assign dac_a_o = dac_regs[0];
  assign dac_b_o = dac_regs[1];
  assign pd_a_o  = pd_flags[0];
  assign pd_b_o  = pd_flags[1];
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_start_i,
  input logic              frm_vld_i,
  input logic              upd_en_i,
  input logic              upd_defer_i,
  input logic              ld_fall_i,
  input logic              pend_i,
  input logic [DATA_W-1:0] in_a_i,
  input logic [DATA_W-1:0] in_b_i,
  input logic [DATA_W-1:0] dac_a_i,
  input logic [DATA_W-1:0] dac_b_i,
  input logic              pd_a_i,
  input logic              pd_b_i
);
  AST_OUT_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_vld_i && !ld_fall_i) |=> ($stable(dac_a_i) && $stable(dac_b_i))); // R3

  AST_PD_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> ($stable(pd_a_i) && $stable(pd_b_i))); // R9

  AST_IMMEDIATE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && upd_en_i && !upd_defer_i) |=> (dac_a_i == in_a_i && dac_b_i == in_b_i)); // R5

  AST_DEFER_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && upd_en_i && upd_defer_i) |=> ($stable(dac_a_i) && $stable(dac_b_i) && pend_i)); // R7

  AST_START_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_start_i |=> !pend_i); // R8

  AST_NO_UPD_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !upd_en_i) |=> !pend_i); // R5
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frm_start_i(frm_start),
  .frm_vld_i  (frm_vld),
  .upd_en_i   (ctrl.upd_en),
  .upd_defer_i(ctrl.upd_defer),
  .ld_fall_i  (ld_fall),
  .pend_i     (pend),
  .in_a_i     (in_regs[0]),
  .in_b_i     (in_regs[1]),
  .dac_a_i    (dac_a_o),
  .dac_b_i    (dac_b_o),
  .pd_a_i     (pd_a_o),
  .pd_b_i     (pd_b_o)
);

// File: tb/dac_cmd_ctrl_tb.sv
module dac_cmd_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] dac_a, dac_b;
  logic       pd_a, pd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] m_in [2];
  logic [7:0] m_out[2];
  logic       m_pd [2];
  logic       m_pend;

  always #5 clk = ~clk;

  dac_cmd_ctrl u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_ni  (cs_n),
    .sclk_i (sclk),
    .din_i  (din),
    .load_ni(load_n),
    .dac_a_o(dac_a),
    .dac_b_o(dac_b),
    .pd_a_o (pd_a),
    .pd_b_o (pd_b)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = '0; m_out[c] = '0; m_pd[c] = 1'b0;
    end
    m_pend = 1'b0;
  endtask

  task automatic model_frame(input logic [15:0] w);
    logic [7:0] ctl;
    ctl = w[15:8];
    for (int c = 0; c < 2; c++) begin
      if (ctl[c]) begin
        m_in[c] = w[7:0];
        m_pd[c] = ctl[4];
      end
    end
    if (ctl[3]) begin
      if (ctl[2]) m_pend = 1'b1;
      else for (int c = 0; c < 2; c++) m_out[c] = m_in[c];
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit split);
    @(negedge clk);
    cs_n = 1'b0;
    m_pend = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      if (split && i == 7) wait_clk(25);
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(10);
    if (nbits == 16) model_frame(w);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load_n = 1'b0;
    wait_clk(4);
    load_n = 1'b1;
    wait_clk(10);
    if (m_pend) begin
      for (int c = 0; c < 2; c++) m_out[c] = m_in[c];
      m_pend = 1'b0;
    end
  endtask

  task automatic check(input string tag);
    n_cmp++;
    if (dac_a !== m_out[0] || dac_b !== m_out[1] || pd_a !== m_pd[0] || pd_b !== m_pd[1]) begin
      n_bad++;
      $display("FAIL %s: got a=%02h b=%02h pd=%b%b expected a=%02h b=%02h pd=%b%b",
               tag, dac_a, dac_b, pd_a, pd_b, m_out[0], m_out[1], m_pd[0], m_pd[1]);
    end
  endtask

  initial begin
    model_reset();
    wait_clk(4);
    check("R10 in reset");
    rst_n = 1'b1;
    wait_clk(4);
    check("R10 after reset");

    // R1: immediate update of channel A, ctrl = 0000_1001
    send(16'h09A5, 16, 1'b0);
    check("R1 R5 R6");

    for (int pass = 0; pass < 2; pass++) begin
      for (int cmd = 0; cmd < 32; cmd++) begin
        logic [7:0] ctl, dat;
        ctl = {3'((cmd * 5 + pass) % 8), 5'(cmd)};
        dat = 8'((cmd * 73 + pass * 29 + 11) % 256);
        send({ctl, dat}, 16, pass == 1);
        if (pass == 1) check("R2 R4 R5 R6 R9 split");
        else           check("R4 R5 R6 R9 sweep");
        pulse_load();
        check("R7 R8 strobe after frame");
      end
    end

    // R7: deferred update of channel B, ctrl = 0000_1110
    send(16'h0E42, 16, 1'b0);
    check("R7 held before strobe");
    pulse_load();
    check("R7 after strobe");

    // R8: pending cancelled by a dropped frame
    send(16'h0D17, 16, 1'b0);
    check("R7 pending");
    send(16'h1F3C, 15, 1'b0);
    check("R3 15 bits dropped");
    pulse_load();
    check("R8 cancelled by frame start");

    // R3: other bad lengths
    send(16'h1B3C, 17, 1'b0);
    check("R3 17 bits dropped");
    send(16'h1B3C, 8, 1'b0);
    check("R3 8 bits dropped");
    send(16'h1B3C, 0, 1'b0);
    check("R3 0 bits dropped");

    // R8: strobe with nothing pending; then expose staging via update-only frame
    send(16'h0177, 16, 1'b0);
    pulse_load();
    check("R8 strobe without pending");
    send(16'hE800, 16, 1'b0);
    check("R4 R5 staging exposed");

    // R9: power down B only, then power up B only
    send(16'h1266, 16, 1'b0);
    check("R9 pd B");
    send(16'h0266, 16, 1'b0);
    check("R9 pu B");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_800_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule